// File: doc/BRIEF.md
# Iterative Integer Divider with Condition Flags

This block performs the integer divide steps of a 32-bit processor datapath. It covers three shapes of divide, each signed or unsigned: a 32-bit dividend over a 16-bit divisor (word form), a 32-bit dividend over a 32-bit divisor (long form), and a 64-bit dividend over a 32-bit divisor (wide form). Every operation returns the quotient, the remainder, the four arithmetic condition flags (N, Z, V, C) and the register write-back pattern that the register file should apply.

The caller samples the current register contents into the operand ports and pulses `start`. The block first converts both operands to magnitudes. A restoring shift-subtract loop then produces one quotient bit per cycle, and the signs are applied at the end. The result appears for exactly one cycle with `done`. A zero divisor skips the loop and raises a trap request. An overflowing quotient updates only the flags. When the quotient and remainder register indices are the same, only the quotient write is issued.

Top module: `div68_unit`

## Requirements
- R1: A zero divisor finishes one cycle after `start` is sampled. It raises `trap_dz` with `done` and asserts neither write enable. For word ops only `dvs[15:0]` is tested for zero.
- R2: `flag_c` is 0 in every `done` cycle, including on overflow.
- R3: A word op without overflow writes one register, `q_idx`, with `q_data = {remainder[15:0], quotient[15:0]}` and keeps `r_we` low.
- R4: A word op overflows when the unsigned quotient exceeds 0xFFFF, or when the signed quotient lies outside -32768..32767.
- R5: On overflow, `flag_v`=1, `flag_z`=0 and `flag_n` equals `n_in` as sampled at `start`, and neither write enable is asserted.
- R6: Without overflow, `flag_v`=0. N and Z are taken from the quotient: bits 15..0 for word ops and bits 31..0 otherwise.
- R7: A wide op divides `{dvd_hi, dvd_lo}` and overflows when the quotient does not fit 32 bits (unsigned) or 32-bit two's complement (signed).
- R8: A long or wide op without overflow writes the quotient to `q_idx` and the remainder to `r_idx`. When the two indices are equal, only the quotient is written.
- R9: Signed division truncates toward zero and the remainder carries the dividend's sign. A signed long op overflows only for 0x80000000 / -1.
- R10: `op[0]` selects signed. `op[2:1]`=00 selects word, 01 selects long (dividend `dvd_lo`), and 1x selects wide.
- R11: With a non-zero divisor, `done` rises exactly 65 cycles after the `start` edge, and `busy` stays high until then. A `start` seen while busy is ignored. After reset, `busy`, `done` and all strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| op | input | 3 | Operation select (R10) |
| dvd_hi | input | 32 | Upper dividend half, wide ops only |
| dvd_lo | input | 32 | Dividend, or lower half for wide ops |
| dvs | input | 32 | Divisor (low 16 bits for word ops) |
| q_idx_in | input | 3 | Quotient register index |
| r_idx_in | input | 3 | Remainder register index |
| n_in | input | 1 | Current N flag, kept on overflow |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle result strobe |
| trap_dz | output | 1 | Divide-by-zero trap request |
| q_we | output | 1 | Quotient register write enable |
| q_idx | output | 3 | Quotient register index |
| q_data | output | 32 | Quotient register data |
| r_we | output | 1 | Remainder register write enable |
| r_idx | output | 3 | Remainder register index |
| r_data | output | 32 | Remainder register data |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |

## Verification
A partial remainder that is wrong at any point corrupts every quotient bit after it. The error therefore shows on `q_data` or `r_data`, and often as a spurious overflow, in the `done` cycle of that same operation, never later. A miscounted step counter appears directly as a `done` latency other than 65 cycles. A wrong latched sign, mode or index shows as a sign, packing or write-enable error in the result of that operation. Random operands are shaped toward small divisors, negative values and wide dividends near the 32-bit limit, so that the overflow boundaries and the aliasing rule are reached often.

// File: rtl/div68_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the iterative divider.
// Assumes op encoding: bit0 = signed, bits[2:1] = 00 word, 01 long, 1x wide.
package div68_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } div_state_t;

    typedef struct packed {
        logic is_signed;
        logic is_word;
        logic is_wide;
    } div_mode_t;

    // Map the raw operation select onto mode bits.
    function automatic div_mode_t decode_op(input logic [2:0] op);
        div_mode_t m;
        m.is_signed = op[0];
        m.is_word   = (op[2:1] == 2'b00);
        m.is_wide   = op[2];
        return m;
    endfunction

endpackage

// File: rtl/div68_prep.sv
`timescale 1ns/1ps
// Module: div68_prep
// Widens dividend and divisor to a common size according to the mode,
// then converts them to magnitudes and reports their signs.
// Assumes DW is even; the word divisor is the low DW/2 bits.
module div68_prep
    import div68_pkg::*;
#(
    parameter int DW = 32
) (
    input  div_mode_t         md,
    input  logic [DW-1:0]     dvd_hi,
    input  logic [DW-1:0]     dvd_lo,
    input  logic [DW-1:0]     dvs_in,
    output logic [2*DW-1:0]   dvd_mag,
    output logic [DW-1:0]     dvs_mag,
    output logic              dvd_neg,
    output logic              dvs_neg,
    output logic              dvs_zero
);
    localparam int QW = 2 * DW;
    localparam int HW = DW / 2;

    logic [QW-1:0] dvd_full;
    logic [DW-1:0] dvs_full;

    // Extend operands per mode, then take absolute values.
    always_comb begin
        if (md.is_wide) dvd_full = {dvd_hi, dvd_lo};
        else            dvd_full = {{DW{md.is_signed & dvd_lo[DW-1]}}, dvd_lo};
        if (md.is_word) dvs_full = {{HW{md.is_signed & dvs_in[HW-1]}}, dvs_in[HW-1:0]};
        else            dvs_full = dvs_in;
        dvd_neg  = md.is_signed & dvd_full[QW-1];
        dvs_neg  = md.is_signed & dvs_full[DW-1];
        dvd_mag  = dvd_neg ? (~dvd_full + 1'b1) : dvd_full;
        dvs_mag  = dvs_neg ? (~dvs_full + 1'b1) : dvs_full;
        dvs_zero = (dvs_full == '0);
    end
endmodule

// File: rtl/div68_core.sv
`timescale 1ns/1ps
// Module: div68_core
// Restoring shift-subtract loop on magnitudes: one quotient bit per step,
// 2*DW steps. The dividend register shifts quotient bits in from the right.
// Assumes the divisor is non-zero whenever step is asserted.
module div68_core #(
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [2*DW-1:0]   dvd_mag,
    input  logic [DW-1:0]     dvs_mag,
    output logic [2*DW-1:0]   quo_mag,
    output logic [DW-1:0]     rem_mag,
    output logic              last
);
    localparam int QW = 2 * DW;
    localparam int CW = $clog2(QW);

    logic [DW-1:0] acc_q;
    logic [DW-1:0] dv_q;
    logic [QW-1:0] sh_q;
    logic [CW-1:0] cnt_q;
    logic [DW:0]   nxt;
    logic          ge;

    // Trial value: partial remainder with next dividend bit appended.
    always_comb begin
        nxt = {acc_q, sh_q[QW-1]};
        ge  = (nxt >= {1'b0, dv_q});
    end

    // Load operands, then shift/subtract once per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            dv_q  <= '0;
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (load) begin
            acc_q <= '0;
            dv_q  <= dvs_mag;
            sh_q  <= dvd_mag;
            cnt_q <= '0;
        end else if (step) begin
            acc_q <= DW'(ge ? (nxt - {1'b0, dv_q}) : nxt);
            sh_q  <= {sh_q[QW-2:0], ge};
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign quo_mag = sh_q;
    assign rem_mag = acc_q;
    assign last    = (cnt_q == CW'(QW - 1));

    // R11: the partial remainder stays below the divisor throughout the loop
    a_r11_partial_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (acc_q < dv_q));
endmodule

// File: rtl/div68_post.sv
`timescale 1ns/1ps
// Module: div68_post
// Applies signs to the loop results, detects overflow for the mode and
// forms flags and the register write-back pattern.
// Assumes magnitudes come from a completed loop with a non-zero divisor.
module div68_post
    import div68_pkg::*;
#(
    parameter int DW  = 32,
    parameter int RIW = 3
) (
    input  div_mode_t         md,
    input  logic [2*DW-1:0]   quo_mag,
    input  logic [DW-1:0]     rem_mag,
    input  logic              dvd_neg,
    input  logic              dvs_neg,
    input  logic [RIW-1:0]    qi,
    input  logic [RIW-1:0]    ri,
    input  logic              n_prev,
    output logic              ovf,
    output logic              q_we,
    output logic              r_we,
    output logic [DW-1:0]     q_data,
    output logic [DW-1:0]     r_data,
    output logic              fn,
    output logic              fz,
    output logic              fv
);
    localparam int QW = 2 * DW;
    localparam int HW = DW / 2;
    localparam logic [QW-1:0] W_NEG = QW'(1) << (HW - 1);
    localparam logic [QW-1:0] W_POS = W_NEG - 1'b1;
    localparam logic [QW-1:0] L_NEG = QW'(1) << (DW - 1);
    localparam logic [QW-1:0] L_POS = L_NEG - 1'b1;

    logic          q_neg;
    logic [DW-1:0] q_val;
    logic [DW-1:0] r_val;

    // Sign fix-up: quotient negative on sign mismatch, remainder follows dividend.
    always_comb begin
        q_neg = md.is_signed & (dvd_neg ^ dvs_neg);
        q_val = q_neg ? (~quo_mag[DW-1:0] + 1'b1) : quo_mag[DW-1:0];
        r_val = dvd_neg ? (~rem_mag + 1'b1) : rem_mag;
    end

    // Overflow test against the destination range of the mode.
    always_comb begin
        if (md.is_word) begin
            if (md.is_signed) ovf = q_neg ? (quo_mag > W_NEG) : (quo_mag > W_POS);
            else              ovf = |quo_mag[QW-1:HW];
        end else begin
            if (md.is_signed) ovf = q_neg ? (quo_mag > L_NEG) : (quo_mag > L_POS);
            else              ovf = |quo_mag[QW-1:DW];
        end
    end

    // Flags and write-back pattern.
    always_comb begin
        if (ovf) begin
            fn = n_prev;
            fz = 1'b0;
            fv = 1'b1;
        end else if (md.is_word) begin
            fn = q_val[HW-1];
            fz = (q_val[HW-1:0] == '0);
            fv = 1'b0;
        end else begin
            fn = q_val[DW-1];
            fz = (q_val == '0);
            fv = 1'b0;
        end
        q_data = md.is_word ? {r_val[HW-1:0], q_val[HW-1:0]} : q_val;
        r_data = r_val;
        q_we   = !ovf;
        r_we   = !ovf && !md.is_word && (qi != ri);
    end
endmodule

// File: rtl/div68_unit.sv
`timescale 1ns/1ps
// Module: div68_unit (top)
// Sequences one divide: captures operands on start, runs the shift-subtract
// core for 2*DW cycles, presents results for one cycle with done.
// Assumes the caller holds operands valid in the start cycle only.
module div68_unit
    import div68_pkg::*;
#(
    parameter int DW  = 32,
    parameter int RIW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        op,
    input  logic [DW-1:0]     dvd_hi,
    input  logic [DW-1:0]     dvd_lo,
    input  logic [DW-1:0]     dvs,
    input  logic [RIW-1:0]    q_idx_in,
    input  logic [RIW-1:0]    r_idx_in,
    input  logic              n_in,
    output logic              busy,
    output logic              done,
    output logic              trap_dz,
    output logic              q_we,
    output logic [RIW-1:0]    q_idx,
    output logic [DW-1:0]     q_data,
    output logic              r_we,
    output logic [RIW-1:0]    r_idx,
    output logic [DW-1:0]     r_data,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_v,
    output logic              flag_c
);
    localparam int QW = 2 * DW;

    div_state_t    st;
    div_mode_t     md_in, md_q;
    logic [QW-1:0] p_dvd_mag, quo_mag;
    logic [DW-1:0] p_dvs_mag, rem_mag;
    logic          p_dvd_neg, p_dvs_neg, p_zero;
    logic          dvd_neg_q, dvs_neg_q, trap_q, n_q;
    logic [RIW-1:0] qi_q, ri_q;
    logic          load, last;
    logic          pq_we, pr_we, pfn, pfz, pfv, povf;
    logic [DW-1:0] pq_data, pr_data;

    assign md_in = decode_op(op);
    assign load  = (st == ST_IDLE) && start && !p_zero;

    div68_prep #(.DW(DW)) u_prep (
        .md(md_in), .dvd_hi(dvd_hi), .dvd_lo(dvd_lo), .dvs_in(dvs),
        .dvd_mag(p_dvd_mag), .dvs_mag(p_dvs_mag),
        .dvd_neg(p_dvd_neg), .dvs_neg(p_dvs_neg), .dvs_zero(p_zero)
    );

    div68_core #(.DW(DW)) u_core (
        .clk(clk), .rst_n(rst_n), .load(load), .step(st == ST_RUN),
        .dvd_mag(p_dvd_mag), .dvs_mag(p_dvs_mag),
        .quo_mag(quo_mag), .rem_mag(rem_mag), .last(last)
    );

    div68_post #(.DW(DW), .RIW(RIW)) u_post (
        .md(md_q), .quo_mag(quo_mag), .rem_mag(rem_mag),
        .dvd_neg(dvd_neg_q), .dvs_neg(dvs_neg_q),
        .qi(qi_q), .ri(ri_q), .n_prev(n_q),
        .ovf(povf), .q_we(pq_we), .r_we(pr_we),
        .q_data(pq_data), .r_data(pr_data),
        .fn(pfn), .fz(pfz), .fv(pfv)
    );

    // Sequencer and per-operation context capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            md_q      <= '0;
            qi_q      <= '0;
            ri_q      <= '0;
            n_q       <= 1'b0;
            dvd_neg_q <= 1'b0;
            dvs_neg_q <= 1'b0;
            trap_q    <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: if (start) begin
                    md_q      <= md_in;
                    qi_q      <= q_idx_in;
                    ri_q      <= r_idx_in;
                    n_q       <= n_in;
                    dvd_neg_q <= p_dvd_neg;
                    dvs_neg_q <= p_dvs_neg;
                    trap_q    <= p_zero;
                    st        <= p_zero ? ST_FIN : ST_RUN;
                end
                ST_RUN:  if (last) st <= ST_FIN;
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Result presentation, gated to the done cycle.
    always_comb begin
        busy    = (st != ST_IDLE);
        done    = (st == ST_FIN);
        trap_dz = done && trap_q;
        q_we    = done && !trap_q && pq_we;
        r_we    = done && !trap_q && pr_we;
        q_idx   = qi_q;
        r_idx   = ri_q;
        q_data  = pq_data;
        r_data  = pr_data;
        flag_n  = trap_q ? n_q : pfn;
        flag_z  = !trap_q && pfz;
        flag_v  = !trap_q && pfv;
        flag_c  = 1'b0;
    end

    // R1: a trap request never comes with a register write
    a_r1_trap_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        trap_dz |-> (!q_we && !r_we));
    // R5: overflow reports V without Z and suppresses writes
    a_r5_overflow_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (done && flag_v) |-> (!q_we && !r_we && !flag_z));
    // R8: both writes only to distinct registers
    a_r8_alias_quotient_wins: assert property (@(posedge clk) disable iff (!rst_n)
        r_we |-> (q_idx != r_idx));
    // R3: word results use a single write
    a_r3_word_single_write: assert property (@(posedge clk) disable iff (!rst_n)
        (q_we && md_q.is_word) |-> !r_we);
    // R11: done is a single-cycle strobe
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R11: an operation in flight is not abandoned
    a_r11_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
endmodule

// File: tb/div68_unit_tb.sv
`timescale 1ns/1ps
module div68_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op = '0;
    logic [31:0] dvd_hi = '0, dvd_lo = '0, dvs = '0;
    logic [2:0]  q_idx_in = '0, r_idx_in = '0;
    logic        n_in = 1'b0;
    logic        busy, done, trap_dz, q_we, r_we, flag_n, flag_z, flag_v, flag_c;
    logic [2:0]  q_idx, r_idx;
    logic [31:0] q_data, r_data;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    div68_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .dvd_hi(dvd_hi), .dvd_lo(dvd_lo), .dvs(dvs),
        .q_idx_in(q_idx_in), .r_idx_in(r_idx_in), .n_in(n_in),
        .busy(busy), .done(done), .trap_dz(trap_dz),
        .q_we(q_we), .q_idx(q_idx), .q_data(q_data),
        .r_we(r_we), .r_idx(r_idx), .r_data(r_data),
        .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One operation with expected values computed from the requirements.
    task automatic do_op(input logic [2:0] o, input logic [31:0] hi, input logic [31:0] lo,
                         input logic [31:0] d, input logic [2:0] qi, input logic [2:0] ri,
                         input logic nin, input bit poke);
        bit sgn, word, wide, zero, ovf;
        logic signed [65:0] a, b, q, r;
        logic [31:0] e_qd, e_rd;
        bit e_rwe, e_n, e_z;
        int n;
        string tov, tdat;
        sgn  = o[0];
        word = (o[2:1] == 2'b00);
        wide = o[2];
        zero = word ? (d[15:0] == 16'h0) : (d == 32'h0);
        if (wide) a = sgn ? {{2{hi[31]}}, hi, lo} : {2'b00, hi, lo};
        else      a = {{34{sgn & lo[31]}}, lo};
        if (word) b = {{50{sgn & d[15]}}, d[15:0]};
        else      b = {{34{sgn & d[31]}}, d};
        q = 0; r = 0; ovf = 0;
        if (!zero) begin
            q = a / b;
            r = a % b;
            if (word) ovf = sgn ? (q < -66'sd32768 || q > 66'sd32767) : (q > 66'sd65535);
            else      ovf = sgn ? (q < -66'sh80000000 || q > 66'sh7FFFFFFF) : (q > 66'shFFFFFFFF);
        end
        tov  = word ? "R4" : (wide ? "R7" : "R9");
        tdat = sgn ? "R9" : (word ? "R3" : "R8");

        @(negedge clk);
        op = o; dvd_hi = hi; dvd_lo = lo; dvs = d;
        q_idx_in = qi; r_idx_in = ri; n_in = nin; start = 1'b1;
        n = 0;
        forever begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (poke && n == 5) begin
                start = 1'b1; op = 3'd1; dvs = 32'h0; dvd_lo = 32'hDEAD_BEEF;
                q_idx_in = ~qi; r_idx_in = ~ri; n_in = ~nin;
            end else start = 1'b0;
            if (done) break;
            if (n > 300) break;
        end
        start = 1'b0;
        chk(n == (zero ? 1 : 65), zero ? "R1 latency" : "R11 latency", 64'(n), zero ? 64'd1 : 64'd65);
        chk(flag_c == 1'b0, "R2 carry", 64'(flag_c), 64'd0);
        chk(trap_dz == zero, "R1 trap", 64'(trap_dz), 64'(zero));
        if (zero) begin
            chk(!q_we && !r_we, "R1 no write", {q_we, r_we}, 64'd0);
        end else if (ovf) begin
            chk(flag_v == 1'b1, {tov, " overflow V"}, 64'(flag_v), 64'd1);
            chk(!q_we && !r_we, "R5 no write", {q_we, r_we}, 64'd0);
            chk(flag_z == 1'b0 && flag_n == nin, "R5 flags", {flag_n, flag_z}, {nin, 1'b0});
        end else begin
            e_qd  = word ? {r[15:0], q[15:0]} : q[31:0];
            e_rd  = r[31:0];
            e_rwe = !word && (qi != ri);
            e_n   = word ? q[15] : q[31];
            e_z   = word ? (q[15:0] == 16'h0) : (q[31:0] == 32'h0);
            chk(flag_v == 1'b0, {tov, " no overflow"}, 64'(flag_v), 64'd0);
            chk(q_we == 1'b1 && q_idx == qi, "R8 quotient write", {q_we, q_idx}, {1'b1, qi});
            chk(q_data == e_qd, {tdat, " quotient data"}, 64'(q_data), 64'(e_qd));
            chk(r_we == e_rwe, word ? "R3 single write" : "R8 alias", 64'(r_we), 64'(e_rwe));
            if (e_rwe) begin
                chk(r_data == e_rd && r_idx == ri, {tdat, " remainder"}, {r_idx, r_data}, {ri, e_rd});
            end
            chk(flag_n == e_n && flag_z == e_z, "R6 flags", {flag_n, flag_z}, {e_n, e_z});
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] hi, lo, d;
        logic [2:0] o;
        void'($urandom(32'd7531));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R11: reset state
        chk(!busy && !done && !q_we && !r_we && !trap_dz, "R11 reset", {busy, done, q_we, r_we, trap_dz}, 64'd0);

        do_op(3'd0, 0, 32'd100000, 32'd7, 3'd1, 3'd2, 0, 0);            // R3 unsigned word
        do_op(3'd0, 0, 32'h12345678, 32'd2, 3'd1, 3'd2, 1, 0);          // R4 unsigned word overflow, R5 keeps N=1
        do_op(3'd1, 0, -32'sd7, 32'h0000_0002, 3'd0, 3'd0, 0, 0);       // R9 -7/2 = -3 rem -1
        do_op(3'd1, 0, 32'hFFFF8000, 32'h0000FFFF, 3'd3, 3'd3, 0, 0);   // R4 signed word -32768/-1
        do_op(3'd0, 0, 32'd55, 32'h0001_0000, 3'd3, 3'd4, 0, 0);        // R1 word zero test on low half
        do_op(3'd2, 0, 32'd55, 32'h0, 3'd3, 3'd4, 0, 0);                // R1 long zero
        do_op(3'd3, 0, 32'h80000000, 32'hFFFFFFFF, 3'd1, 3'd2, 1, 0);   // R9 long signed overflow
        do_op(3'd3, 0, -32'sd100, 32'd7, 3'd1, 3'd2, 0, 0);             // R9 long signed
        do_op(3'd2, 0, 32'd1000, 32'd10, 3'd5, 3'd5, 0, 0);             // R8 alias, quotient wins
        do_op(3'd4, 32'd1, 32'd0, 32'd1, 3'd1, 3'd2, 0, 0);             // R7 wide overflow
        do_op(3'd4, 32'd1, 32'd0, 32'd2, 3'd1, 3'd2, 0, 0);             // R7 wide, fits
        do_op(3'd5, 32'hFFFFFFFF, -32'sd100, 32'd7, 3'd6, 3'd7, 0, 0);  // R7 R9 wide signed
        do_op(3'd6, 32'd0, 32'd99, 32'd9, 3'd1, 3'd2, 0, 0);            // R10 op 6 acts as wide unsigned
        do_op(3'd2, 0, 32'd0, 32'd5, 3'd1, 3'd2, 0, 0);                 // R6 zero quotient sets Z
        do_op(3'd2, 0, 32'd12345, 32'd11, 3'd1, 3'd2, 0, 1);            // R11 start while busy ignored

        for (int i = 0; i < 300; i++) begin
            o  = 3'($urandom_range(0, 5));
            lo = $urandom;
            case ($urandom_range(0, 3))
                0: hi = $urandom;
                1: hi = {32{lo[31]}};
                default: hi = $urandom & 32'h0000_00FF;
            endcase
            case ($urandom_range(0, 4))
                0: d = $urandom;
                1: d = $urandom_range(1, 255);
                2: d = $urandom & 32'h0000_FFFF;
                3: d = -$urandom_range(1, 100);
                default: d = ($urandom_range(0, 9) == 0) ? 32'h0 : ($urandom | 32'h8000_0000);
            endcase
            do_op(o, hi, lo, d, 3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)), 0);
        end

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule